// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors held in host memory and turns each owned descriptor into a stream of bytes. A one-cycle poll strobe wakes it from idle while the run enable is high. It then reads the four leading words of the current descriptor over a single word-wide memory master port. Bit 31 of the control word marks the descriptor as owned by the engine. If that bit is clear, the engine returns to idle and waits for the next poll. If it is set, the engine reads the data from the first buffer and then from the second, and presents the bytes one per cycle on a valid/ready output. Each byte carries flags for start of frame, end of frame and CRC append.

When a descriptor is finished, the engine writes its control word back with the ownership bit cleared and the status bits filled in. It can raise a completion pulse. It then moves to the next descriptor, or back to the list base when the descriptor carries the wrap flag, and keeps going until it finds a descriptor that it does not own. If the consumer holds off a byte for too long, the engine abandons the frame and records an underflow. Buffers may start and end at any byte address. Each 32-bit memory word is read little-endian: byte lane 0 holds the lowest address.

Top module: `txd_engine`

## Requirements
- R1: After reset, mem_req, tx_valid and done_irq are low, and the current descriptor pointer equals list_base.
- R2: A poll_req pulse taken while run_en is high and the engine is idle starts a read of word 0 at the current pointer. A poll_req with run_en low causes no memory access. Descriptor word k is read from the byte address pointer + 4*k, for k = 0..3.
- R3: If bit 31 (ownership) of word 0 is clear, the engine emits no byte, performs no write and goes idle. The next poll re-reads the same descriptor.
- R4: Buffer 1 starts at the byte address in word 2 and holds word1[12:0] bytes. Buffer 2 starts at the byte address in word 3 and holds word1[28:16] bytes. All buffer-1 bytes go out before any buffer-2 byte, in ascending address order. Byte lane n of a memory word, bits 8n+7:8n, is address 4*word+n. A zero length skips that buffer.
- R5: tx_first is high on the first byte of a descriptor only if word0[28] is set. tx_last is high on its final byte only if word0[29] is set. tx_crc equals word0[25] on every byte of that descriptor.
- R6: Write-back stores to the word-0 address the original word 0 with bit 31 cleared and bits 15 and 0 set to the underflow outcome. All other bits are unchanged, including the wrap bit 21.
- R7: After write-back the pointer advances by DESC_BYTES, or returns to list_base when word0[21] is set. With run_en still high, the engine fetches the next descriptor without a new poll.
- R8: With stall_limit nonzero, if tx_valid stays high and tx_ready stays low for stall_limit consecutive cycles, the engine drops the rest of the descriptor's bytes, with no tx_last. It then writes back with bits 15 and 0 set. A stall_limit of 0 never aborts.
- R9: done_irq is a one-cycle pulse in the cycle after the write-back completes, and only when word0[30] of that descriptor is set.
- R10: The memory port has one transfer in flight at a time. mem_req, mem_we and mem_addr hold steady until mem_ack. Each descriptor word and each buffer word touched is read exactly once.
- R11: While run_en is low and the engine is idle, the pointer follows list_base. A descriptor already in progress is completed, and the engine then idles with the pointer at list_base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable; low parks the pointer at the list base |
| poll_req | input | 1 | One-cycle poll demand |
| list_base | input | 32 | Byte address of the first ring descriptor |
| stall_limit | input | STALL_W | Consumer stall cycles before abort, 0 disables |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer complete; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Consumer accepts byte |
| tx_data | output | 8 | Output byte |
| tx_first | output | 1 | First byte of frame |
| tx_last | output | 1 | Final byte of frame |
| tx_crc | output | 1 | CRC append requested for this frame |
| done_irq | output | 1 | Completion pulse |

## Verification
The checks assume a memory responder that raises mem_ack for one cycle per request and never acknowledges when mem_req is low. They also assume tx_ready moves only between clock edges. The bench's memory model acknowledges one cycle after a new request and drops the acknowledge at once. The consumer's ready pattern changes only on falling edges. Descriptors are rewritten only while the engine is idle, after the bench has waited long enough for the ring walk to stop. Every byte address used lies inside the 4 KiB modelled memory.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 13;

  localparam int OWN_B = 31;
  localparam int IRQ_B = 30;
  localparam int LS_B  = 29;
  localparam int FS_B  = 28;
  localparam int CRC_B = 25;
  localparam int EOR_B = 21;
  localparam int ES_B  = 15;
  localparam int UF_B  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC, ST_BSEL, ST_BREAD, ST_EMIT, ST_WB
  } txd_state_e;

  // status word returned to memory
  function automatic logic [WORD_W-1:0] wb_word(input logic [WORD_W-1:0] w0,
                                                input logic uf);
    logic [WORD_W-1:0] r;
    r        = w0;
    r[OWN_B] = 1'b0;
    r[ES_B]  = uf;
    r[UF_B]  = uf;
    return r;
  endfunction

  // pointer after a finished descriptor
  function automatic logic [ADDR_W-1:0] next_ptr(input logic [ADDR_W-1:0] cur,
                                                 input logic [ADDR_W-1:0] base,
                                                 input logic wrap,
                                                 input logic [ADDR_W-1:0] step);
    return wrap ? base : cur + step;
  endfunction

  // address of descriptor word k
  function automatic logic [ADDR_W-1:0] desc_word_addr(input logic [ADDR_W-1:0] p,
                                                       input logic [1:0] k);
    return p + {{(ADDR_W-4){1'b0}}, k, 2'b00};
  endfunction

  // final byte of the whole descriptor
  function automatic logic final_byte(input logic [LEN_W-1:0] rem,
                                      input logic bsel,
                                      input logic [LEN_W-1:0] len2);
    return (rem == LEN_W'(1)) && (bsel || (len2 == '0));
  endfunction
endpackage

// File: rtl/txd_byte_pick.sv
module txd_byte_pick #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0]         word,
  input  logic [$clog2(LANES)-1:0]   sel,
  output logic [7:0]                 pick
);
  logic [7:0] lane [LANES];
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane[i] = word[8*i +: 8];
  end
  assign pick = lane[sel];
endmodule

// File: rtl/txd_stall_timer.sv
module txd_stall_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stalled,
  input  logic [CNT_W-1:0] limit,
  output logic             abort
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !stalled) cnt <= '0;
    else                    cnt <= cnt + CNT_W'(1);
  end

  assign abort = stalled && (limit != '0) && (cnt == limit - CNT_W'(1));
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int DESC_BYTES = 32,
  parameter int STALL_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               poll_req,
  input  logic [31:0]        list_base,
  input  logic [STALL_W-1:0] stall_limit,
  output logic               mem_req,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  output logic               tx_first,
  output logic               tx_last,
  output logic               tx_crc,
  output logic               done_irq
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  txd_state_e        state;
  logic [ADDR_W-1:0] ptr;
  logic [WORD_W-1:0] w0, a1, a2, word_buf;
  logic [LEN_W-1:0]  len1, len2, rem;
  logic [ADDR_W-1:0] baddr;
  logic [1:0]        widx;
  logic              bsel, first_pend, uf;

  // named internal events
  logic wb_fire, byte_fire, stall_abort, stalled;

  assign wb_fire   = (state == ST_WB) && mem_ack;
  assign tx_valid  = (state == ST_EMIT);
  assign byte_fire = tx_valid && tx_ready;
  assign stalled   = tx_valid && !tx_ready;

  txd_stall_timer #(.CNT_W(STALL_W)) u_stall (
    .clk(clk), .rst_n(rst_n), .stalled(stalled),
    .limit(stall_limit), .abort(stall_abort)
  );

  txd_byte_pick #(.LANES(WORD_W/8)) u_pick (
    .word(word_buf), .sel(baddr[1:0]), .pick(tx_data)
  );

  assign tx_first = first_pend && w0[FS_B];
  assign tx_last  = w0[LS_B] && final_byte(rem, bsel, len2);
  assign tx_crc   = w0[CRC_B];

  assign mem_req   = (state == ST_DESC) || (state == ST_BREAD) || (state == ST_WB);
  assign mem_we    = (state == ST_WB);
  assign mem_wdata = wb_word(w0, uf);

  always_comb begin
    case (state)
      ST_DESC:  mem_addr = desc_word_addr(ptr, widx);
      ST_BREAD: mem_addr = {baddr[ADDR_W-1:2], 2'b00};
      default:  mem_addr = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ptr        <= list_base;
      w0         <= '0;
      a1         <= '0;
      a2         <= '0;
      len1       <= '0;
      len2       <= '0;
      rem        <= '0;
      baddr      <= '0;
      word_buf   <= '0;
      widx       <= '0;
      bsel       <= 1'b0;
      first_pend <= 1'b0;
      uf         <= 1'b0;
      done_irq   <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!run_en) ptr <= list_base;
          else if (poll_req) begin
            widx  <= '0;
            state <= ST_DESC;
          end
        end
        ST_DESC: begin
          if (mem_ack) begin
            case (widx)
              2'd0: begin
                w0 <= mem_rdata;
                if (!mem_rdata[OWN_B]) state <= ST_IDLE;
              end
              2'd1: begin
                len1 <= mem_rdata[LEN_W-1:0];
                len2 <= mem_rdata[16 +: LEN_W];
              end
              2'd2: a1 <= mem_rdata;
              default: begin
                a2         <= mem_rdata;
                bsel       <= 1'b0;
                first_pend <= 1'b1;
                uf         <= 1'b0;
                state      <= ST_BSEL;
              end
            endcase
            widx <= widx + 2'd1;
          end
        end
        ST_BSEL: begin
          if (!bsel) begin
            if (len1 != '0) begin
              baddr <= a1;
              rem   <= len1;
              state <= ST_BREAD;
            end else bsel <= 1'b1;
          end else if (len2 != '0) begin
            baddr <= a2;
            rem   <= len2;
            state <= ST_BREAD;
          end else state <= ST_WB;
        end
        ST_BREAD: begin
          if (mem_ack) begin
            word_buf <= mem_rdata;
            state    <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (stall_abort) begin
            uf    <= 1'b1;
            state <= ST_WB;
          end else if (byte_fire) begin
            first_pend <= 1'b0;
            rem        <= rem - LEN_W'(1);
            baddr      <= baddr + ADDR_W'(1);
            if (rem == LEN_W'(1)) begin
              if (!bsel) begin
                bsel  <= 1'b1;
                state <= ST_BSEL;
              end else state <= ST_WB;
            end else if (baddr[1:0] == 2'b11) state <= ST_BREAD;
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            done_irq <= w0[IRQ_B];
            widx     <= '0;
            if (run_en) begin
              ptr   <= next_ptr(ptr, list_base, w0[EOR_B], STEP);
              state <= ST_DESC;
            end else begin
              ptr   <= list_base;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        done_irq,
  input logic        stall_abort,
  input logic        wb_fire
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R6
  own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R9
  irq_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(wb_fire));

  // R8
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_abort |-> tx_valid && !tx_ready);

  // R4
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !stall_abort |=> tx_valid && $stable(tx_data));

  // R10
  one_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_req));
endmodule

bind txd_engine txd_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .done_irq(done_irq), .stall_abort(stall_abort), .wb_fire(wb_fire)
);

// File: tb/txd_engine_tb_top.sv
module txd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic poll_req = 1'b0;
  logic [15:0] stall_limit = 16'd0;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic tx_valid, tx_ready, tx_first, tx_last, tx_crc, done_irq;
  logic [7:0] tx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll_req(poll_req),
    .list_base(BASE), .stall_limit(stall_limit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last), .tx_crc(tx_crc),
    .done_irq(done_irq)
  );

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, irq_cnt = 0, hs_total = 0, stall_base = 0;
  int ready_mode = 0, cyc = 0;
  bit done = 0;
  logic [31:0] mem [1024];
  logic [10:0] exp_q [$];

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], 4'h5};
  endfunction

  // memory responder
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // consumer + scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = (cyc % 3) != 0;
      default: tx_ready = (hs_total - stall_base) < 3;
    endcase
    if (done_irq) irq_cnt++;
    if (rst_n && tx_valid && tx_ready) begin
      hs_total++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected byte actual=%h expected=none", tx_data);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        if ({tx_first, tx_last, tx_crc, tx_data} !== e) begin
          fails++;
          $display("FAIL R4/R5 byte actual=%h expected=%h",
                   {tx_first, tx_last, tx_crc, tx_data}, e);
        end
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic poll();
    poll_req = 1'b1;
    @(negedge clk);
    #1 poll_req = 1'b0;
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [31:0] w0,
                          input logic [31:0] w1, input logic [31:0] w2,
                          input logic [31:0] w3);
    mem[a[11:2]] = w0; mem[a[11:2]+1] = w1;
    mem[a[11:2]+2] = w2; mem[a[11:2]+3] = w3;
  endtask

  // driver: push expected bytes for one descriptor
  task automatic push_frame(input bit fs, input bit ls, input bit crc,
                            input int a1, input int l1, input int a2,
                            input int l2, input int keep);
    int tot = l1 + l2;
    for (int i = 0; i < tot && i < keep; i++) begin
      logic [31:0] ad;
      ad = (i < l1) ? a1 + i : a2 + (i - l1);
      exp_q.push_back({fs && i == 0, ls && i == tot-1 && keep >= tot, crc, pat(ad)});
    end
  endtask

  initial begin
    int cy = 0;
    while (!done && cy < 100000) begin @(posedge clk); cy++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cy);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 1024; w++)
      for (int b = 0; b < 4; b++) mem[w][8*b +: 8] = pat(32'(w*4 + b));
    for (int w = 64; w < 96; w++) mem[w] = '0;
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R1 reset state
    chk(!mem_req && !tx_valid && !done_irq, "R1 idle outputs", {mem_req, tx_valid, done_irq}, 0);

    // R2 poll ignored with run_en low
    poll();
    settle(10);
    chk(rd_cnt == 0, "R2 no access with run_en low", rd_cnt, 0);

    // R4/R5/R9: two owned descriptors, third not owned
    run_en = 1'b1;
    set_desc(BASE,       32'hF200_0000, (6<<16)|5, 32'h401, 32'h50A);
    set_desc(BASE+32'h20, 32'h9000_0000, 3, 32'h603, 0);
    push_frame(1, 1, 1, 'h401, 5, 'h50A, 6, 99);
    push_frame(1, 0, 0, 'h603, 3, 0, 0, 99);
    settle(2);
    poll();
    settle(200);
    chk(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);
    chk(mem[BASE[11:2]] == 32'h7200_0000, "R6 wb desc0", mem[BASE[11:2]], 32'h7200_0000);
    chk(mem[(BASE[11:2])+8] == 32'h1000_0000, "R6 wb desc1", mem[(BASE[11:2])+8], 32'h1000_0000);
    chk(mem[(BASE[11:2])+16] == 0, "R3 unowned desc2 untouched", mem[(BASE[11:2])+16], 0);
    chk(irq_cnt == 1, "R9 one completion pulse", irq_cnt, 1);
    chk(rd_cnt == 15, "R10 one read per word", rd_cnt, 15);
    chk(wr_cnt == 2, "R7 walked ring without new poll", wr_cnt, 2);

    // R7 wrap bit, toggling consumer
    ready_mode = 1;
    set_desc(BASE+32'h40, 32'hA020_0000, 4, 32'h700, 0);
    push_frame(0, 1, 0, 'h700, 4, 0, 0, 99);
    poll();
    settle(150);
    chk(mem[(BASE[11:2])+16] == 32'h2020_0000, "R6 wrap bit kept", mem[(BASE[11:2])+16], 32'h2020_0000);
    chk(exp_q.size() == 0, "R4 toggling consumer", exp_q.size(), 0);
    ready_mode = 0;
    set_desc(BASE, 32'hB000_0000, 7<<16, 0, 32'h801);
    push_frame(1, 1, 0, 0, 0, 'h801, 7, 99);
    poll();
    settle(150);
    chk(mem[BASE[11:2]] == 32'h3000_0000, "R7 wrapped to base, buffer2 only", mem[BASE[11:2]], 32'h3000_0000);
    chk(wr_cnt == 4, "R7 write count", wr_cnt, 4);

    // R3 poll on unowned descriptor
    poll();
    settle(50);
    chk(wr_cnt == 4, "R3 no write when not owned", wr_cnt, 4);
    chk(!tx_valid && !mem_req, "R3 idle after unowned", {tx_valid, mem_req}, 0);

    // R8 stall abort
    stall_limit = 16'd4;
    stall_base = hs_total;
    ready_mode = 2;
    set_desc(BASE+32'h20, 32'hB200_0000, 8, 32'h900, 0);
    push_frame(1, 1, 1, 'h900, 8, 0, 0, 3);
    poll();
    settle(120);
    chk(mem[(BASE[11:2])+8] == 32'h3200_8001, "R8 underflow write-back", mem[(BASE[11:2])+8], 32'h3200_8001);
    chk(exp_q.size() == 0, "R8 only bytes before stall", exp_q.size(), 0);
    chk(irq_cnt == 1, "R9 no pulse without irq bit", irq_cnt, 1);
    ready_mode = 0;
    settle(5);

    // R11 run_en low returns pointer to base
    run_en = 1'b0;
    settle(5);
    run_en = 1'b1;
    set_desc(BASE, 32'hF000_0000, 2, 32'hA02, 0);
    push_frame(1, 1, 0, 'hA02, 2, 0, 0, 99);
    poll();
    settle(100);
    chk(mem[BASE[11:2]] == 32'h7000_0000, "R11 restart at base", mem[BASE[11:2]], 32'h7000_0000);
    chk(irq_cnt == 2, "R9 second pulse", irq_cnt, 2);
    chk(exp_q.size() == 0, "R11 bytes delivered", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule